// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a small serial memory. It oversamples the two-wire clock and data lines on a fast system clock and recognises bus framing events on them. It receives the slave address byte and decides whether this device is being addressed. It then turns the transfer into simple request strobes for a separate memory controller. For a write, the controller receives one strobe per data byte, carrying the target address space, a 9-bit address and the byte. For a read, the controller receives one strobe per byte and returns the byte on `rd_data_i`.

The memory controller owns the storage and any internal write cycle. While that cycle runs, the controller raises `busy_i` and the engine stays silent on the bus. The data line is driven only through a pull-low enable, which suits an open-drain pad.

Top module: `serial_mem_slave`

## Requirements
- R1: A START (data falling while clock is high) begins reception of a new slave address byte from any state. A STOP (data rising while clock is high) returns the engine to idle with `sda_oe_o` low. After reset `sda_oe_o`, `req_wr_o` and `req_rd_o` are low.
- R2: Bytes are shifted MSB first. In the slave address byte, bits [7:4] hold the type code, bits [3:2] must equal `bus_sel_i`, bit [1] is address bit 8, and bit [0] is the direction (1 = read, 0 = write).
- R3: Type code 1010 selects space 0 (main memory), 1011 selects space 1 (alternate memory) and 1001 selects space 2 (configuration). Any other code, or a bus-select mismatch, gets no acknowledge, and the engine ignores the bus until the next START or STOP.
- R4: An accepted byte is acknowledged with `sda_oe_o` high from the clock fall after the eighth bit until the clock fall after the ninth.
- R5: In a write, the byte after the slave address byte loads address bits [7:0]. Every later byte is acknowledged and produces one `req_wr_o` pulse with that address and data. After each such byte, address bits [7:0] increment, wrapping from 0xFF to 0x00, and bit 8 is kept.
- R6: In a read, a `req_rd_o` pulse is issued at the current address. `rd_data_i` is sampled on the second clock edge after the pulse. The byte is sent MSB first, with `sda_oe_o` equal to the inverse of each bit, and `sda_oe_o` changes only while the synchronised clock is low.
- R7: A master acknowledge on the ninth bit of a read byte increments address bits [7:0] and issues a new `req_rd_o` for the next byte. A master NACK releases the line, and no further bits or strobes follow until a START or STOP.
- R8: While `busy_i` is high when a slave address byte completes, the engine gives no acknowledge and issues no strobe until the next START.
- R9: A repeated START during a transfer restarts address reception and keeps the stored word address, so a write of the word address followed by a repeated START and a read returns data from that address.
- R10: `req_wr_o` and `req_rd_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull-low enable for the data line |
| bus_sel_i | input | 2 | Strapped bus-select value matched against the address byte |
| busy_i | input | 1 | Memory controller internal write in progress |
| req_space_o | output | 2 | Target space of the request (0 main, 1 alternate, 2 config) |
| req_addr_o | output | DW+1 | Request address |
| req_wdata_o | output | DW | Write data for `req_wr_o` |
| req_wr_o | output | 1 | Write request strobe |
| req_rd_o | output | 1 | Read request strobe |
| rd_data_i | input | DW | Read data returned by the controller |

## Verification
Writes to main and alternate memory check that the acknowledge slots, per-byte strobes and address increments line up. A write starting at 0xFE shows whether the low byte wraps while bit 8 is kept. Random reads with a repeated START, including one from configuration space, show whether the stored word address survives the restart. A read ended by NACK is followed by an extra clocked byte, which tells a correctly silent engine apart from one that keeps driving. Bad type codes, a wrong bus select and a raised busy flag each expect a missing acknowledge and no strobe at all. These cases separate rejection of the address byte from rejection of the later traffic.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_DEVADR  = 3'd1,
    S_WORDADR = 3'd2,
    S_WRDATA  = 3'd3,
    S_RDDATA  = 3'd4,
    S_WAIT    = 3'd5
  } smem_st_e;

  localparam logic [3:0] TYPE_MAIN = 4'b1010;
  localparam logic [3:0] TYPE_ALT  = 4'b1011;
  localparam logic [3:0] TYPE_CFG  = 4'b1001;

  localparam logic [1:0] SPACE_MAIN = 2'd0;
  localparam logic [1:0] SPACE_ALT  = 2'd1;
  localparam logic [1:0] SPACE_CFG  = 2'd2;

  // {valid, space}
  function automatic logic [2:0] decode_type(input logic [3:0] code);
    case (code)
      TYPE_MAIN: decode_type = {1'b1, SPACE_MAIN};
      TYPE_ALT:  decode_type = {1'b1, SPACE_ALT};
      TYPE_CFG:  decode_type = {1'b1, SPACE_CFG};
      default:   decode_type = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{INIT}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/smem_line_events.sv
module smem_line_events #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_w;
  logic [NLINES-1:0] syn_w;
  logic [NLINES-1:0] prev_q;

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    smem_sync #(.STAGES(STAGES), .INIT(1'b1)) sync_i (
      .clk (clk),
      .rst (rst),
      .d   (raw_w[g]),
      .q   (syn_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= {NLINES{1'b1}};
    else     prev_q <= syn_w;
  end

  assign scl_s    = syn_w[0];
  assign sda_s    = syn_w[1];
  assign scl_rise = syn_w[0] & ~prev_q[0];
  assign scl_fall = ~syn_w[0] & prev_q[0];
  assign start_ev = syn_w[0] & prev_q[0] & prev_q[1] & ~syn_w[1];
  assign stop_ev  = syn_w[0] & prev_q[0] & ~prev_q[1] & syn_w[1];
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import smem_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [1:0]    bus_sel_i,
  input  logic          busy_i,
  output logic [1:0]    req_space_o,
  output logic [DW:0]   req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  output logic          req_wr_o,
  output logic          req_rd_o,
  input  logic [DW-1:0] rd_data_i
);
  localparam int AW = DW + 1;
  localparam int CW = $clog2(DW + 1);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [DW-1:0] LO_ONE   = DW'(1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  smem_line_events #(.STAGES(SYNC_STAGES)) ev_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smem_st_e      st_q;
  logic [CW-1:0] cnt_q;
  logic          ack_ph_q;
  logic [DW-1:0] sh_q;
  logic [DW-1:0] rbyte_q;
  logic          ld_q;
  logic          rw_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    type_dec;
  logic [IW-1:0] bidx;
  logic          dev_match;
  logic [DW-1:0] lo_next;

  assign type_dec  = decode_type(sh_q[DW-1:DW-4]);
  assign dev_match = type_dec[2] && (sh_q[3:2] == bus_sel_i) && !busy_i;
  assign bidx      = IW'(DW - 1) - cnt_q[IW-1:0];
  assign lo_next   = addr_q[DW-1:0] + LO_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      ack_ph_q    <= 1'b0;
      sh_q        <= '0;
      rbyte_q     <= '0;
      ld_q        <= 1'b0;
      rw_q        <= 1'b0;
      addr_q      <= '0;
      sda_oe_o    <= 1'b0;
      req_space_o <= SPACE_MAIN;
      req_addr_o  <= '0;
      req_wdata_o <= '0;
      req_wr_o    <= 1'b0;
      req_rd_o    <= 1'b0;
    end else begin
      req_wr_o <= 1'b0;
      req_rd_o <= 1'b0;
      ld_q     <= req_rd_o;
      if (ld_q) rbyte_q <= rd_data_i;

      if (stop_ev) begin
        st_q     <= S_IDLE;
        sda_oe_o <= 1'b0;
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
      end else if (start_ev) begin
        st_q     <= S_DEVADR;
        sda_oe_o <= 1'b0;
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
      end else begin
        case (st_q)
          S_DEVADR, S_WORDADR, S_WRDATA: begin
            if (scl_rise && cnt_q != CNT_FULL) begin
              sh_q  <= {sh_q[DW-2:0], sda_s};
              cnt_q <= cnt_q + CNT_ONE;
            end else if (scl_fall && cnt_q == CNT_FULL && !ack_ph_q) begin
              ack_ph_q <= 1'b1;
              if (st_q == S_DEVADR) begin
                if (dev_match) begin
                  sda_oe_o       <= 1'b1;
                  req_space_o    <= type_dec[1:0];
                  rw_q           <= sh_q[0];
                  addr_q[AW-1]   <= sh_q[1];
                  if (sh_q[0]) begin
                    req_rd_o   <= 1'b1;
                    req_addr_o <= {sh_q[1], addr_q[DW-1:0]};
                  end
                end else begin
                  st_q <= S_WAIT;
                end
              end else if (st_q == S_WORDADR) begin
                sda_oe_o         <= 1'b1;
                addr_q[DW-1:0]   <= sh_q;
              end else begin
                sda_oe_o         <= 1'b1;
                req_wr_o         <= 1'b1;
                req_addr_o       <= addr_q;
                req_wdata_o      <= sh_q;
                addr_q[DW-1:0]   <= lo_next;
              end
            end else if (scl_fall && ack_ph_q) begin
              ack_ph_q <= 1'b0;
              cnt_q    <= '0;
              if (st_q == S_DEVADR && rw_q) begin
                st_q     <= S_RDDATA;
                sda_oe_o <= ~rbyte_q[DW-1];
              end else begin
                sda_oe_o <= 1'b0;
                if (st_q == S_DEVADR)       st_q <= S_WORDADR;
                else if (st_q == S_WORDADR) st_q <= S_WRDATA;
              end
            end
          end
          S_RDDATA: begin
            if (scl_rise) begin
              if (cnt_q == CNT_FULL) begin
                cnt_q <= '0;
                if (!sda_s) begin
                  addr_q[DW-1:0] <= lo_next;
                  req_rd_o       <= 1'b1;
                  req_addr_o     <= {addr_q[AW-1], lo_next};
                end else begin
                  st_q <= S_WAIT;
                end
              end else begin
                cnt_q <= cnt_q + CNT_ONE;
              end
            end else if (scl_fall) begin
              if (cnt_q == CNT_FULL) sda_oe_o <= 1'b0;
              else                   sda_oe_o <= ~rbyte_q[bidx];
            end
          end
          default: begin
            sda_oe_o <= 1'b0;
          end
        endcase
      end
    end
  end

  // Strobes are one-cycle pulses (R10 / R5 / R6)
  assert_pulse_wr_R5: assert property (@(posedge clk) disable iff (rst)
    req_wr_o |=> !req_wr_o);
  assert_pulse_rd_R6: assert property (@(posedge clk) disable iff (rst)
    req_rd_o |=> !req_rd_o);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(req_wr_o && req_rd_o));
  // Data line moves only while the bus clock is low, except on framing events
  assert_sda_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> (!scl_s || $past(start_ev || stop_ev)));
  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (st_q == S_IDLE && !sda_oe_o));
  assert_start_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (start_ev && !stop_ev) |=> (st_q == S_DEVADR && cnt_q == '0));
  assert_busy_noack_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DEVADR && busy_i && scl_fall && cnt_q == CNT_FULL && !ack_ph_q
     && !start_ev && !stop_ev) |=> (!sda_oe_o && !req_rd_o));
endmodule

// File: tb/serial_mem_slave_tb.sv
module serial_mem_slave_tb_top;
  localparam int DW = 8;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [1:0] bus_sel = 2'b10;
  logic busy = 1'b0;
  logic [1:0] req_space;
  logic [DW:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic req_wr, req_rd;
  logic [DW-1:0] rd_data = '0;
  logic line;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  int q_kind[$];
  int q_addr[$];
  int q_space[$];
  int q_data[$];

  always #2.5 clk = ~clk;
  assign line = m_sda & ~sda_oe;

  serial_mem_slave #(.DW(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(line), .sda_oe_o(sda_oe),
    .bus_sel_i(bus_sel), .busy_i(busy), .req_space_o(req_space),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata), .req_wr_o(req_wr),
    .req_rd_o(req_rd), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] pat(input int addr, input int sp);
    pat = 8'((addr * 3) + (sp * 8'h51) + 8'h1D);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // controller model: returns a pattern byte after a read strobe
  always @(posedge clk) if (req_rd) rd_data <= pat(int'(req_addr), int'(req_space));

  // reference comparison of strobes on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (req_wr && req_rd) chk(0, "R10 both strobes", 1, 0);
      if (req_wr || req_rd) begin
        if (q_kind.size() == 0) begin
          chk(0, "R10 unexpected strobe", int'(req_addr), -1);
        end else begin
          int k, a, s, d;
          k = q_kind.pop_front(); a = q_addr.pop_front();
          s = q_space.pop_front(); d = q_data.pop_front();
          chk(k == int'(req_rd), k ? "R6 strobe kind" : "R5 strobe kind", int'(req_rd), k);
          chk(int'(req_addr) == a, k ? "R7 strobe addr" : "R5 strobe addr", int'(req_addr), a);
          chk(int'(req_space) == s, "R3 strobe space", int'(req_space), s);
          if (!k) chk(int'(req_wdata) == d, "R5 write data", int'(req_wdata), d);
        end
      end
    end
  end

  task automatic waitq(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq();
    m_sda = 1'b0; waitq(); m_scl = 1'b0; waitq();
  endtask

  task automatic bstop();
    m_sda = 1'b0; waitq(); m_scl = 1'b1; waitq(); m_sda = 1'b1; waitq();
  endtask

  task automatic bbit(input logic b, output logic seen);
    m_sda = b; waitq(); m_scl = 1'b1; waitq(); seen = line; waitq();
    m_scl = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) bbit(v[i], s);
    bbit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bbit(1'b1, s); v[i] = s; end
    bbit(give_ack ? 1'b0 : 1'b1, s);
  endtask

  function automatic logic [7:0] abyte(input logic [3:0] t, input logic [1:0] sel,
                                       input logic a8, input logic rw);
    abyte = {t, sel, a8, rw};
  endfunction

  task automatic push(input int k, input int a, input int s, input int d);
    q_kind.push_back(k); q_addr.push_back(a); q_space.push_back(s); q_data.push_back(d);
  endtask

  task automatic do_write(input logic [3:0] t, input int sp, input logic a8,
                          input logic [7:0] word, input int n, input logic [7:0] d0);
    bit ack;
    logic [7:0] lo;
    lo = word;
    bstart();
    send_byte(abyte(t, bus_sel, a8, 1'b0), ack); chk(ack, "R4 write addr ack", ack, 1);
    send_byte(word, ack); chk(ack, "R5 word addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      push(0, {a8, lo}, sp, 8'(d0 + i));
      send_byte(8'(d0 + i), ack); chk(ack, "R5 data ack", ack, 1);
      lo = lo + 8'd1;
    end
    bstop();
    chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
  endtask

  task automatic do_read(input logic [3:0] t, input int sp, input logic a8,
                         input logic [7:0] word, input int n);
    bit ack;
    logic [7:0] lo, v;
    lo = word;
    bstart();
    send_byte(abyte(t, bus_sel, a8, 1'b0), ack); chk(ack, "R9 setup ack", ack, 1);
    send_byte(word, ack); chk(ack, "R9 word ack", ack, 1);
    bstart();
    push(1, {a8, lo}, sp, 0);
    send_byte(abyte(t, bus_sel, a8, 1'b1), ack); chk(ack, "R9 read addr ack after restart", ack, 1);
    for (int i = 0; i < n; i++) begin
      if (i < n - 1) push(1, {a8, 8'(lo + 8'd1)}, sp, 0);
      recv_byte(i < n - 1, v);
      chk(v == pat({a8, lo}, sp), "R6 read byte", v, pat({a8, lo}, sp));
      if (i < n - 1) lo = lo + 8'd1;
    end
    recv_byte(1'b0, v);
    chk(v == 8'hFF, "R7 silent after nack", v, 8'hFF);
    bstop();
  endtask

  task automatic do_reject(input logic [7:0] ab, input string req);
    bit ack;
    bstart();
    send_byte(ab, ack); chk(!ack, req, ack, 0);
    send_byte(8'h00, ack); chk(!ack, req, ack, 0);
    bstop();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(sda_oe == 0 && req_wr == 0 && req_rd == 0, "R1 reset state",
        {sda_oe, req_wr, req_rd}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    do_write(4'b1010, 0, 1'b0, 8'h10, 3, 8'hA5);     // R5 main space
    do_write(4'b1011, 1, 1'b1, 8'hFE, 3, 8'h3C);     // R5 wrap 0xFF->0x00, bit 8 kept; R3 alt
    do_read (4'b1010, 0, 1'b1, 8'h40, 3);            // R6 R7 R9
    do_read (4'b1001, 2, 1'b0, 8'hFF, 2);            // R3 config, R7 wrap on read
    do_reject(abyte(4'b1100, bus_sel, 1'b0, 1'b0), "R3 bad type no ack");
    do_reject(abyte(4'b1010, 2'b01, 1'b0, 1'b0), "R3 bus select mismatch no ack");
    busy = 1'b1;
    do_reject(abyte(4'b1010, bus_sel, 1'b0, 1'b0), "R8 busy write no ack");
    do_reject(abyte(4'b1010, bus_sel, 1'b0, 1'b1), "R8 busy read no ack");
    busy = 1'b0;
    do_write(4'b1010, 0, 1'b0, 8'h77, 1, 8'h5A);     // R2 recovery after rejects
    repeat (20) @(negedge clk);
    chk(q_kind.size() == 0, "R10 all expected strobes seen", q_kind.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule